// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits between a 16-bit instruction fetch port on the bus side and an execution unit that consumes instruction bytes one at a time. It keeps a small store of prefetched bytes and asks for a new word from the bus by itself whenever enough room is free. A completed fetch adds two bytes, low byte first, when the fetch address is even. When the address is odd it adds only the high byte of the returned word.

Bytes leave in the order they arrived through a valid/ready byte port. When the queue is empty, the first byte of an arriving word is shown to the consumer in the same clock, so a fetch after a branch costs no extra cycle. A flush input, asserted for one clock when control flow changes, empties the store and discards any word returned in that clock. It also loads a new fetch address.

Top module: `instruction_prefetch_queue`

## Requirements
- R1: After reset, out_valid is 0, fetch_req is 1 and fetch_addr equals the RESET_ADDR parameter (default 0).
- R2: Outside a flush clock, fetch_req is 1 exactly when at least THRESH (default 2) of the DEPTH byte slots are free. A fetch is accepted in a clock where fetch_req and fetch_ack are both 1.
- R3: The queue never holds more than DEPTH (default 6) bytes. A fetch_ack while fetch_req is 0 is ignored: no byte is stored and fetch_addr does not move.
- R4: Bytes reach out_data in the order they were accepted. A byte that is offered and not taken stays on out_data.
- R5: When the queue is empty and a fetch is accepted, out_valid is 1 in that same clock, and out_data carries the first accepted byte of the word.
- R6: At an even fetch_addr, an accepted word gives fetch_data[7:0] and then fetch_data[15:8], and fetch_addr advances by 2.
- R7: At an odd fetch_addr, only fetch_data[15:8] is stored and fetch_addr advances by 1.
- R8: In a flush clock, out_valid and fetch_req are 0 and any fetch_ack is discarded. After that clock the queue is empty and fetch_addr equals the flush_addr that was presented.
- R9: A write and a read in the same clock are both carried out, and the occupancy changes by the net amount. This includes a read of the byte that bypasses an empty queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty the queue and reload the fetch address |
| flush_addr | input | ADDR_W | Fetch address to load on flush |
| fetch_req | output | 1 | Word fetch requested |
| fetch_addr | output | ADDR_W | Byte address of the next fetch |
| fetch_ack | input | 1 | Fetch completes with data this clock |
| fetch_data | input | 16 | Returned instruction word |
| out_valid | output | 1 | A byte is offered to the consumer |
| out_data | output | 8 | Offered byte |
| out_ready | input | 1 | Consumer takes the offered byte |

## Verification
The bench fills the queue with even and odd start addresses so that it ends at six and at five bytes. At those levels the request must drop; a design that compares against the wrong threshold would overflow, or would stall one word early. A fetch returned in a flush clock must not come out after the flush, and a bogus acknowledge while the request is low must leave the contents and the address unchanged. The bench takes the bypassed byte in the very clock it arrives and reads while writing at several fill levels. An off-by-one in the net count or the bypass pointer would drop or duplicate a byte in the drained sequence.

// File: rtl/ifq_pkg.sv
// Shared types for the instruction prefetch queue.
package ifq_pkg;
    typedef logic [7:0]  byte_t;
    typedef logic [15:0] word_t;
    // Number of bytes a completed fetch contributes this clock.
    typedef enum logic [1:0] {
        TAKE_NONE = 2'd0,
        TAKE_ONE  = 2'd1,
        TAKE_TWO  = 2'd2
    } take_e;
endpackage

// File: rtl/ifq_fetch_ctrl.sv
// Fetch address and request control.
// Holds the byte address of the next fetch and raises the request when enough
// slots are free. It decides how many bytes of a returned word are kept.
// Assumes the returned data is valid in the same clock as the acknowledge.
module ifq_fetch_ctrl
    import ifq_pkg::*;
#(
    parameter int DEPTH      = 6,
    parameter int THRESH     = 2,
    parameter int ADDR_W     = 20,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
    localparam int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic [CNT_W-1:0]  occ,
    input  logic              fetch_ack,
    input  word_t             fetch_data,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output take_e             take,
    output byte_t             in0,
    output byte_t             in1
);
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  free_slots;
    logic              accept;
    logic              odd;

    // Request decision from the free slot count.
    always_comb begin
        free_slots = CNT_W'(DEPTH) - occ;
        fetch_req  = !flush && (free_slots >= CNT_W'(THRESH));
        accept     = fetch_req && fetch_ack;
        odd        = addr_q[0];
    end

    // Byte selection from the returned word.
    always_comb begin
        in0  = odd ? fetch_data[15:8] : fetch_data[7:0];
        in1  = fetch_data[15:8];
        take = !accept ? TAKE_NONE : (odd ? TAKE_ONE : TAKE_TWO);
    end

    // Fetch address register: reload on flush, advance on accept.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= RESET_ADDR;
        else if (flush)
            addr_q <= flush_addr;
        else if (accept)
            addr_q <= addr_q + (odd ? ADDR_W'(1) : ADDR_W'(2));
    end

    assign fetch_addr = addr_q;
endmodule

// File: rtl/ifq_byte_store.sv
// Circular byte store with a same-clock bypass.
// Accepts zero, one or two bytes per clock and releases one byte per clock.
// When empty, it offers the first incoming byte directly.
// Assumes the writer never offers more bytes than there are free slots.
module ifq_byte_store
    import ifq_pkg::*;
#(
    parameter int DEPTH  = 6,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  take_e            take,
    input  byte_t            in0,
    input  byte_t            in1,
    input  logic             out_ready,
    output logic             out_valid,
    output byte_t            out_data,
    output logic [CNT_W-1:0] occ
);
    byte_t            mem [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q, wr_b;
    logic [CNT_W-1:0] occ_q;
    logic [1:0]       n_in, n_wr;
    logic             have_stored, pop, skip;
    byte_t            first_b;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Offer, pop and bypass decisions.
    always_comb begin
        n_in        = take;
        have_stored = (occ_q != '0);
        out_valid   = !flush && (have_stored || (n_in != 2'd0));
        out_data    = have_stored ? mem[rd_q] : in0;
        pop         = out_valid && out_ready;
        skip        = !have_stored && pop;
        first_b     = skip ? in1 : in0;
        n_wr        = n_in - {1'b0, skip};
        wr_b        = ptr_inc(wr_q);
    end

    // One register per slot, written at the first or second write position.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (!flush) begin
                if (n_wr != 2'd0 && wr_q == PTR_W'(i))
                    mem[i] <= first_b;
                else if (n_wr == 2'd2 && wr_b == PTR_W'(i))
                    mem[i] <= in1;
            end
        end
    end

    // Pointer and occupancy update by the net change.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_q  <= '0;
            wr_q  <= '0;
            occ_q <= '0;
        end else begin
            if (n_wr == 2'd2)
                wr_q <= ptr_inc(wr_b);
            else if (n_wr == 2'd1)
                wr_q <= wr_b;
            if (pop && have_stored)
                rd_q <= ptr_inc(rd_q);
            occ_q <= occ_q + CNT_W'(n_in) - CNT_W'(pop);
        end
    end

    assign occ = occ_q;
endmodule

// File: rtl/instruction_prefetch_queue.sv
// Instruction prefetch queue top.
// Joins the fetch control to the byte store. The bus side sees a request
// with a byte address and completes it with an acknowledge plus a 16-bit word.
// The consumer side is a valid/ready byte port. Assumes THRESH >= 2.
module instruction_prefetch_queue
    import ifq_pkg::*;
#(
    parameter int DEPTH  = 6,
    parameter int THRESH = 2,
    parameter int ADDR_W = 20,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_ack,
    input  logic [15:0]       fetch_data,
    output logic              out_valid,
    output logic [7:0]        out_data,
    input  logic              out_ready
);
    logic [CNT_W-1:0] occ;
    take_e            take;
    byte_t            in0, in1;

    ifq_fetch_ctrl #(
        .DEPTH(DEPTH), .THRESH(THRESH), .ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
        .occ(occ), .fetch_ack(fetch_ack), .fetch_data(fetch_data),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .take(take), .in0(in0), .in1(in1)
    );

    ifq_byte_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .take(take),
        .in0(in0), .in1(in1), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .occ(occ)
    );
endmodule

// File: rtl/ifq_checker.sv
// Property checker for the instruction prefetch queue, bound to the top.
module ifq_checker #(
    parameter int DEPTH  = 6,
    parameter int THRESH = 2,
    parameter int ADDR_W = 20,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic [ADDR_W-1:0] flush_addr,
    input logic              fetch_req,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              fetch_ack,
    input logic [15:0]       fetch_data,
    input logic              out_valid,
    input logic [7:0]        out_data,
    input logic              out_ready,
    input logic [CNT_W-1:0]  occ
);
    // R3: occupancy bound
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    // R2: an empty queue outside flush always requests
    a_r2_empty_requests: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && occ == '0) |-> fetch_req);

    // R8: flush silences both sides, then leaves the queue empty at the new address
    a_r8_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!fetch_req && !out_valid));
    a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occ == '0 && fetch_addr == $past(flush_addr)));

    // R6: even accept advances by two
    a_r6_even_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_ack && !fetch_addr[0]) |=>
            fetch_addr == $past(fetch_addr) + ADDR_W'(2));

    // R7: odd accept advances by one
    a_r7_odd_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_ack && fetch_addr[0]) |=>
            fetch_addr == $past(fetch_addr) + ADDR_W'(1));

    // R5: bypass of the first byte into an empty queue
    a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_ack && occ == '0) |->
            (out_valid && out_data == (fetch_addr[0] ? fetch_data[15:8] : fetch_data[7:0])));

    // R4: an offered stored byte that is not taken is held
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && occ != '0) |=>
            (flush || (out_valid && $stable(out_data))));
endmodule

bind instruction_prefetch_queue ifq_checker #(
    .DEPTH(DEPTH), .THRESH(THRESH), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
    .fetch_data(fetch_data), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .occ(occ)
);

// File: tb/tb_instruction_prefetch_queue.sv
// Directed bench for the instruction prefetch queue.
module tb_instruction_prefetch_queue;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush = 1'b0;
    logic [ADDR_W-1:0] flush_addr = '0;
    logic              fetch_req;
    logic [ADDR_W-1:0] fetch_addr;
    logic              fetch_ack = 1'b0;
    logic [15:0]       fetch_data = '0;
    logic              out_valid;
    logic [7:0]        out_data;
    logic              out_ready = 1'b0;

    logic              s_valid, s_req;
    logic [7:0]        s_data;
    logic [ADDR_W-1:0] s_addr;
    int                n_chk = 0;
    int                n_fail = 0;
    bit                done = 0;

    instruction_prefetch_queue dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
        .fetch_data(fetch_data), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready)
    );

    always #(CLK_P/2) clk = ~clk;

    // Compare one value and count the result.
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one clock starting at a falling edge; sample outputs before the rising edge.
    task automatic cyc(input logic ack, input logic [15:0] d, input logic rdy,
                       input logic fl, input logic [ADDR_W-1:0] fa);
        fetch_ack = ack; fetch_data = d; out_ready = rdy; flush = fl; flush_addr = fa;
        #2;
        s_valid = out_valid; s_data = out_data; s_req = fetch_req; s_addr = fetch_addr;
        @(negedge clk);
        fetch_ack = 1'b0; out_ready = 1'b0; flush = 1'b0;
    endtask

    task automatic idle();
        cyc(1'b0, 16'h0, 1'b0, 1'b0, '0);
    endtask

    task automatic do_flush(input logic [ADDR_W-1:0] a);
        cyc(1'b0, 16'h0, 1'b0, 1'b1, a);
    endtask

    // Take one byte and compare it.
    task automatic take_one(input string tag, input logic [7:0] b);
        cyc(1'b0, 16'h0, 1'b1, 1'b0, '0);
        chk({tag, " valid"}, 32'(s_valid), 32'd1);
        chk({tag, " data"}, 32'(s_data), 32'(b));
    endtask

    task automatic t_reset();
        idle();
        chk("R1 out_valid after reset", 32'(s_valid), 32'd0);
        chk("R1 fetch_req after reset", 32'(s_req), 32'd1);
        chk("R1 fetch_addr after reset", 32'(s_addr), 32'h0);
    endtask

    task automatic t_bypass_even();
        cyc(1'b1, 16'hBBAA, 1'b0, 1'b0, '0);
        chk("R5 bypass valid", 32'(s_valid), 32'd1);
        chk("R5 bypass data", 32'(s_data), 32'hAA);
        idle();
        chk("R6 addr +2", 32'(s_addr), 32'h2);
        chk("R4 held byte", 32'(s_data), 32'hAA);
        take_one("R6 low first", 8'hAA);
        take_one("R6 high second", 8'hBB);
        idle();
        chk("R6 empty after drain", 32'(s_valid), 32'd0);
    endtask

    task automatic t_fill_even();
        do_flush(20'h00200);
        chk("R8 flush valid low", 32'(s_valid), 32'd0);
        chk("R8 flush req low", 32'(s_req), 32'd0);
        cyc(1'b1, 16'h2211, 1'b0, 1'b0, '0);
        cyc(1'b1, 16'h4433, 1'b0, 1'b0, '0);
        cyc(1'b1, 16'h6655, 1'b0, 1'b0, '0);
        chk("R2 req with 2 free", 32'(s_req), 32'd1);
        idle();
        chk("R3 req low when full", 32'(s_req), 32'd0);
        chk("R6 addr after 3 words", 32'(s_addr), 32'h00206);
        cyc(1'b1, 16'h8877, 1'b0, 1'b0, '0);
        idle();
        chk("R3 ignored ack addr", 32'(s_addr), 32'h00206);
        take_one("R4 order 1", 8'h11);
        take_one("R4 order 2", 8'h22);
        take_one("R4 order 3", 8'h33);
        take_one("R4 order 4", 8'h44);
        take_one("R4 order 5", 8'h55);
        take_one("R3 order 6", 8'h66);
        idle();
        chk("R3 ignored ack stored nothing", 32'(s_valid), 32'd0);
    endtask

    task automatic t_fill_odd();
        do_flush(20'h00401);
        idle();
        chk("R8 addr loaded", 32'(s_addr), 32'h00401);
        chk("R8 req after flush", 32'(s_req), 32'd1);
        cyc(1'b1, 16'hA1B0, 1'b0, 1'b0, '0);
        chk("R7 odd bypass high byte", 32'(s_data), 32'hA1);
        cyc(1'b1, 16'hA3A2, 1'b0, 1'b0, '0);
        chk("R7 addr +1", 32'(s_addr), 32'h00402);
        cyc(1'b1, 16'hA5A4, 1'b0, 1'b0, '0);
        idle();
        chk("R2 req low with 1 free", 32'(s_req), 32'd0);
        chk("R7 addr after fill", 32'(s_addr), 32'h00406);
        take_one("R7 seq 1", 8'hA1);
        take_one("R7 seq 2", 8'hA2);
        take_one("R7 seq 3", 8'hA3);
        take_one("R7 seq 4", 8'hA4);
        take_one("R7 seq 5", 8'hA5);
        idle();
        chk("R7 empty after drain", 32'(s_valid), 32'd0);
    endtask

    task automatic t_flush_discard();
        cyc(1'b1, 16'h1234, 1'b0, 1'b0, '0);
        cyc(1'b1, 16'h9999, 1'b0, 1'b1, 20'h00500);
        chk("R8 valid low in flush", 32'(s_valid), 32'd0);
        chk("R8 req low in flush", 32'(s_req), 32'd0);
        idle();
        chk("R8 empty after flush", 32'(s_valid), 32'd0);
        chk("R8 new addr", 32'(s_addr), 32'h00500);
        cyc(1'b1, 16'h5678, 1'b0, 1'b0, '0);
        chk("R8 first byte after flush", 32'(s_data), 32'h78);
        take_one("R8 post flush 1", 8'h78);
        take_one("R8 post flush 2", 8'h56);
        idle();
        chk("R8 discarded word absent", 32'(s_valid), 32'd0);
    endtask

    task automatic t_simultaneous();
        do_flush(20'h00600);
        cyc(1'b1, 16'h2211, 1'b0, 1'b0, '0);
        cyc(1'b1, 16'h4433, 1'b1, 1'b0, '0);
        chk("R9 read while write 1", 32'(s_data), 32'h11);
        cyc(1'b1, 16'h6655, 1'b1, 1'b0, '0);
        chk("R9 read while write 2", 32'(s_data), 32'h22);
        chk("R9 req at net count 3", 32'(s_req), 32'd1);
        take_one("R9 rest 1", 8'h33);
        take_one("R9 rest 2", 8'h44);
        take_one("R9 rest 3", 8'h55);
        take_one("R9 rest 4", 8'h66);
        idle();
        chk("R9 empty after net drain", 32'(s_valid), 32'd0);
        cyc(1'b1, 16'hA2A1, 1'b1, 1'b0, '0);
        chk("R9 bypass taken", 32'(s_data), 32'hA1);
        take_one("R9 after bypass pop", 8'hA2);
        idle();
        chk("R9 empty after bypass pop", 32'(s_valid), 32'd0);
        chk("R6 addr after 4 words", 32'(s_addr), 32'h00608);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bypass_even();
        t_fill_even();
        t_fill_odd();
        t_flush_discard();
        t_simultaneous();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule